// File: doc/BRIEF.md
# Radio Operating Mode Controller

This block holds the three operating control bits of a packet radio: transmit enable, receive enable and synthesizer enable (tune). It reports one operating state derived from those bits. Software loads the bits with a register write. When the radio moves payload through its internal buffers (buffered mode), the packet engine's events end a transmission or a reception by clearing only the bit that started it. The state then falls back to whatever the remaining bits select.

Receive errors (CRC, header, sync) never end reception. Each error raises a sticky interrupt flag, as do the packet-sent and packet-valid events. All flags are combined into one active-low interrupt line. Each flag stays set until software pulses its clear bit.

Top module: `radio_opmode_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) all control bits are 0, the state is idle, every flag is 0 and irq_n is 1.
- R2: A write (ctl_wr_en high) loads ctl_wdata, with bit 2 = transmit enable, bit 1 = receive enable and bit 0 = tune enable. The state is visible from the next edge, with the encoding idle=0, tune=1, rx=2, tx=3. The priority is tx over rx over tune over idle.
- R3: In buffered mode (buf_mode high), pkt_sent while the state is tx clears only the transmit bit at the next edge. The state then becomes rx if receive is set, else tune if tune is set, else idle.
- R4: In buffered mode, pkt_valid while the state is rx clears only the receive bit. pkt_valid while the state is not rx leaves all bits unchanged.
- R5: crc_err, hdr_err and sync_err leave the control bits and the rx state unchanged.
- R6: With buf_mode low, pkt_sent and pkt_valid change no control bit.
- R7: The flags use the bit order 0=sent, 1=valid, 2=crc, 3=header, 4=sync. An event sets its flag at the next edge. A flag stays set until its irq_clr bit is pulsed. An event in the same cycle as the clear leaves the flag set.
- R8: irq_n is low exactly when at least one flag is set.
- R9: When a write and an automatic clear coincide, the automatic clear wins on its own bit, and the other written bits take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_mode | input | 1 | Buffered payload mode; enables automatic exit |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word {tx, rx, tune} |
| pkt_sent | input | 1 | Packet fully transmitted |
| pkt_valid | input | 1 | Valid packet received |
| crc_err | input | 1 | Receive CRC error |
| hdr_err | input | 1 | Receive header error |
| sync_err | input | 1 | Receive sync error |
| irq_clr | input | 5 | Per-flag clear pulses |
| ctl_bits | output | 3 | Live control bits {tx, rx, tune} |
| op_state | output | 2 | Current operating state |
| irq_flags | output | 5 | Sticky interrupt flags |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
A wrong control bit shows on ctl_bits and op_state one edge after the write or event that caused it. A missed or spurious automatic clear therefore shows up in the very next comparison. A flag that is not sticky, or that is cleared too early, shows on irq_flags and irq_n in the cycle after the event or clear pulse. Fall-back cases are driven with every combination of the remaining bits, so a wrong priority order appears as a wrong state code. The same holds for a clear that touches the wrong bit.

// File: rtl/opmode_pkg.sv
// Shared types for the radio operating mode controller.
// Assumes the control word is ordered {tx, rx, tune} from MSB to LSB.
package opmode_pkg;
    localparam int CTL_W  = 3;
    localparam int IRQ_W  = 5;
    localparam int ST_W   = 2;

    localparam int IRQ_SENT  = 0;
    localparam int IRQ_VALID = 1;
    localparam int IRQ_CRC   = 2;
    localparam int IRQ_HDR   = 3;
    localparam int IRQ_SYNC  = 4;

    typedef enum logic [ST_W-1:0] {
        OPS_IDLE = 2'd0,
        OPS_TUNE = 2'd1,
        OPS_RX   = 2'd2,
        OPS_TX   = 2'd3
    } opstate_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic tune;
    } ctl_bits_t;
endpackage

// File: rtl/opmode_ctrl_bits.sv
// Control bit register. It loads the software word on a write and
// applies the hardware clears, which win on their own bit.
// Assumes the clear strobes are single-cycle and already qualified.
module opmode_ctrl_bits
    import opmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  ctl_bits_t wr_data,
    input  logic      tx_auto_clr,
    input  logic      rx_auto_clr,
    output ctl_bits_t ctl_next,
    output ctl_bits_t ctl_q
);
    // Next value: the write replaces the word, then the hardware clears apply.
    always_comb begin
        ctl_next = wr_en ? wr_data : ctl_q;
        if (tx_auto_clr) ctl_next.tx = 1'b0;
        if (rx_auto_clr) ctl_next.rx = 1'b0;
    end

    // Register the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_next;
    end

    AST_TX_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_auto_clr |=> !ctl_q.tx); // R9
    AST_RX_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_auto_clr |=> !ctl_q.rx); // R4
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tx_auto_clr && !rx_auto_clr) |=> $stable(ctl_q)); // R5
endmodule

// File: rtl/opmode_state_sel.sv
// Operating state register. It registers the priority decode of the next
// control bits, so the state and the bits change on the same edge.
module opmode_state_sel
    import opmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_bits_t ctl_next,
    output opstate_e  state_q
);
    opstate_e state_d;

    // Priority decode: tx, then rx, then tune, else idle.
    always_comb begin
        if (ctl_next.tx)        state_d = OPS_TX;
        else if (ctl_next.rx)   state_d = OPS_RX;
        else if (ctl_next.tune) state_d = OPS_TUNE;
        else                    state_d = OPS_IDLE;
    end

    // Register the state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OPS_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/opmode_irq_flags.sv
// Sticky interrupt flags. Each bit is set by its event, cleared by its clear
// pulse, and the set wins if both arrive together. The active-low line is
// the OR of all flags.
module opmode_irq_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags_q,
    output logic         irq_n
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            // One sticky flag per event source.
            always_ff @(posedge clk) begin
                if (!rst_n)      flags_q[i] <= 1'b0;
                else if (evt[i]) flags_q[i] <= 1'b1;
                else if (clr[i]) flags_q[i] <= 1'b0;
            end

            AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> flags_q[i]); // R7
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_q[i] && !clr[i]) |=> flags_q[i]); // R7
        end
    endgenerate

    // Combine the flags into the active-low line.
    always_comb irq_n = ~(|flags_q);
endmodule

// File: rtl/radio_opmode_ctrl.sv
// Top of the radio operating mode controller. It qualifies the packet events
// into automatic exits, keeps the control bits and the state, and raises the
// interrupt flags. Assumes all event inputs are single-cycle pulses that are
// synchronous to clk.
module radio_opmode_ctrl
    import opmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_mode,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             pkt_sent,
    input  logic             pkt_valid,
    input  logic             crc_err,
    input  logic             hdr_err,
    input  logic             sync_err,
    input  logic [IRQ_W-1:0] irq_clr,
    output logic [CTL_W-1:0] ctl_bits,
    output logic [ST_W-1:0]  op_state,
    output logic [IRQ_W-1:0] irq_flags,
    output logic             irq_n
);
    ctl_bits_t        ctl_q;
    ctl_bits_t        ctl_next;
    opstate_e         state_q;
    logic             tx_auto_clr;
    logic             rx_auto_clr;
    logic [IRQ_W-1:0] evt_vec;

    // Qualify the automatic exits by buffered mode and the current state.
    always_comb begin
        tx_auto_clr = buf_mode && (state_q == OPS_TX) && pkt_sent;
        rx_auto_clr = buf_mode && (state_q == OPS_RX) && pkt_valid;
    end

    // Gather the event pulses in flag order.
    always_comb begin
        evt_vec            = '0;
        evt_vec[IRQ_SENT]  = pkt_sent;
        evt_vec[IRQ_VALID] = pkt_valid;
        evt_vec[IRQ_CRC]   = crc_err;
        evt_vec[IRQ_HDR]   = hdr_err;
        evt_vec[IRQ_SYNC]  = sync_err;
    end

    opmode_ctrl_bits u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctl_wr_en),
        .wr_data     (ctl_bits_t'(ctl_wdata)),
        .tx_auto_clr (tx_auto_clr),
        .rx_auto_clr (rx_auto_clr),
        .ctl_next    (ctl_next),
        .ctl_q       (ctl_q)
    );

    opmode_state_sel u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_next (ctl_next),
        .state_q  (state_q)
    );

    opmode_irq_flags #(.N(IRQ_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_vec),
        .clr     (irq_clr),
        .flags_q (irq_flags),
        .irq_n   (irq_n)
    );

    assign ctl_bits = ctl_q;
    assign op_state = state_q;

    AST_TX_STATE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.tx |-> (state_q == OPS_TX)); // R2
    AST_RX_STATE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.tx && ctl_q.rx) |-> (state_q == OPS_RX)); // R2
    AST_SENT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && state_q == OPS_TX && pkt_sent) |=> (state_q != OPS_TX)); // R3
    AST_ERR_STAY_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OPS_RX && !ctl_wr_en && !pkt_valid && (crc_err || hdr_err || sync_err))
        |=> (state_q == OPS_RX)); // R5
    AST_DIRECT_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_mode && !ctl_wr_en) |=> $stable(ctl_q)); // R6
    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_flags) |-> !irq_n); // R8
endmodule

// File: tb/radio_opmode_ctrl_tb_top.sv
module radio_opmode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_mode = 1'b1;
    logic       ctl_wr_en = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic       pkt_sent = 1'b0, pkt_valid = 1'b0;
    logic       crc_err = 1'b0, hdr_err = 1'b0, sync_err = 1'b0;
    logic [4:0] irq_clr = '0;
    logic [2:0] ctl_bits;
    logic [1:0] op_state;
    logic [4:0] irq_flags;
    logic       irq_n;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    radio_opmode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode),
        .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
        .pkt_sent(pkt_sent), .pkt_valid(pkt_valid),
        .crc_err(crc_err), .hdr_err(hdr_err), .sync_err(sync_err),
        .irq_clr(irq_clr), .ctl_bits(ctl_bits), .op_state(op_state),
        .irq_flags(irq_flags), .irq_n(irq_n)
    );

    typedef struct {
        string      tag;
        logic [2:0] bits;
        logic [1:0] st;
        logic [4:0] flg;
        logic       irqn;
    } exp_t;

    exp_t exp_q[$];

    // Reference state, built from the requirements.
    logic [2:0] m_bits = '0;
    logic [4:0] m_flags = '0;

    function automatic logic [1:0] prio(input logic [2:0] b);
        if (b[2])      return 2'd3;
        else if (b[1]) return 2'd2;
        else if (b[0]) return 2'd1;
        else           return 2'd0;
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (ctl_bits !== e.bits || op_state !== e.st || irq_flags !== e.flg || irq_n !== e.irqn) begin
            failures++;
            $display("FAIL %s: bits=%b state=%0d flags=%b irq_n=%b expected bits=%b state=%0d flags=%b irq_n=%b",
                     e.tag, ctl_bits, op_state, irq_flags, irq_n, e.bits, e.st, e.flg, e.irqn);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected outcome.
    // evt order: 0 sent, 1 valid, 2 crc, 3 header, 4 sync.
    task automatic step(input string tag, input logic wr, input logic [2:0] wd,
                        input logic bm, input logic [4:0] evt, input logic [4:0] clr);
        exp_t e;
        logic [2:0] nb;
        logic [1:0] cur;
        @(negedge clk);
        buf_mode = bm; ctl_wr_en = wr; ctl_wdata = wd;
        pkt_sent = evt[0]; pkt_valid = evt[1]; crc_err = evt[2];
        hdr_err = evt[3]; sync_err = evt[4]; irq_clr = clr;
        cur = prio(m_bits);
        nb = wr ? wd : m_bits;
        if (bm && cur == 2'd3 && evt[0]) nb[2] = 1'b0;
        if (bm && cur == 2'd2 && evt[1]) nb[1] = 1'b0;
        m_bits = nb;
        m_flags = (m_flags & ~clr) | evt;
        e.tag = tag; e.bits = m_bits; e.st = prio(m_bits);
        e.flg = m_flags; e.irqn = (m_flags == 5'd0);
        exp_q.push_back(e);
    endtask

    // Monitor: compare one expected item after each edge that has one.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) compare(exp_q.pop_front());
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        r.tag = "R1"; r.bits = 3'b000; r.st = 2'd0; r.flg = 5'd0; r.irqn = 1'b1;
        compare(r);
        @(negedge clk); rst_n = 1'b1;

        // R2: write and state priority
        step("R2", 1, 3'b001, 1, 5'd0, 5'd0);
        step("R2", 1, 3'b011, 1, 5'd0, 5'd0);
        step("R2", 1, 3'b111, 1, 5'd0, 5'd0);
        step("R2", 1, 3'b000, 1, 5'd0, 5'd0);
        // R3: transmit exit, fall back to tune, idle, rx
        step("R3", 1, 3'b101, 1, 5'd0, 5'd0);
        step("R3", 0, 3'b000, 1, 5'b00001, 5'd0);
        step("R7", 0, 3'b000, 1, 5'd0, 5'b00001);
        step("R3", 1, 3'b100, 1, 5'd0, 5'd0);
        step("R3", 0, 3'b000, 1, 5'b00001, 5'b00001);
        step("R3", 1, 3'b110, 1, 5'd0, 5'b00001);
        step("R3", 0, 3'b000, 1, 5'b00001, 5'd0);
        // R4: receive exit and pkt_valid outside rx
        step("R4", 1, 3'b011, 1, 5'd0, 5'b11111);
        step("R4", 0, 3'b000, 1, 5'b00010, 5'd0);
        step("R4", 1, 3'b110, 1, 5'd0, 5'b11111);
        step("R4", 0, 3'b000, 1, 5'b00010, 5'd0);
        step("R4", 1, 3'b001, 1, 5'd0, 5'b11111);
        step("R4", 0, 3'b000, 1, 5'b00010, 5'd0);
        // R5 / R8: errors keep rx, flags and interrupt line
        step("R5", 1, 3'b010, 1, 5'd0, 5'b11111);
        step("R5", 0, 3'b000, 1, 5'b00100, 5'd0);
        step("R5", 0, 3'b000, 1, 5'b01000, 5'd0);
        step("R5", 0, 3'b000, 1, 5'b10000, 5'd0);
        step("R8", 0, 3'b000, 1, 5'd0, 5'b01100);
        step("R8", 0, 3'b000, 1, 5'd0, 5'b10000);
        // R7: event and clear together keeps the flag set
        step("R7", 0, 3'b000, 1, 5'b00100, 5'b00100);
        step("R7", 0, 3'b000, 1, 5'd0, 5'd0);
        step("R7", 0, 3'b000, 1, 5'd0, 5'b00100);
        // R6: no automatic exit outside buffered mode
        step("R6", 1, 3'b100, 0, 5'd0, 5'd0);
        step("R6", 0, 3'b000, 0, 5'b00001, 5'd0);
        step("R6", 1, 3'b010, 0, 5'd0, 5'b11111);
        step("R6", 0, 3'b000, 0, 5'b00010, 5'd0);
        // R9: write coinciding with automatic clear
        step("R9", 1, 3'b100, 1, 5'd0, 5'b11111);
        step("R9", 1, 3'b101, 1, 5'b00001, 5'd0);
        step("R9", 1, 3'b010, 1, 5'd0, 5'b11111);
        step("R9", 1, 3'b011, 1, 5'b00010, 5'd0);
        step("R2", 0, 3'b000, 1, 5'd0, 5'd0);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule